// File: doc/BRIEF.md
# Bit-Level Systolic Unsigned Multiplier

This block multiplies two streams of small unsigned integers, one pair per clock, and produces a stream of full-width products. The core is a lattice of identical one-bit cells. Each cell forms the AND of one multiplicand bit and one multiplier bit, adds it with full-adder logic to an incoming partial-sum bit and an incoming carry bit, and registers the result. Cells connect only to their direct neighbours. Multiplicand bits travel down the rows, two registers per row. Multiplier bits travel across the columns, one register per column. Partial sums move diagonally to the next row, and carries move to the next column. No operand bit is fanned out to more than one cell. An extra column of carry-catching cells, one per row, holds the top bit that each row's carry chain produces.

The block registers the operands at the port and then staggers each bit by a chain of registers, so that it meets its partners at the right cell in the right cycle. The product bits leave the lattice at different times. A deskew bank of shift registers aligns them into one word and presents that word with a matching valid flag. An upstream stage presents a pair together with `in_valid`, and the aligned product appears a fixed number of cycles later. The pipeline accepts a new pair on every cycle.

Top module: `systolic_mul`

## Requirements
- R1: For every pair sampled with `in_valid` high, `out_p` equals the unsigned product `in_a * in_b`, 2*W bits wide (W = 4, giving 8 bits).
- R2: The latency is fixed at 3*W = 12 cycles. A pair sampled at rising edge N appears on `out_valid` and `out_p` right after rising edge N+12. An isolated pair gives a single-cycle `out_valid` pulse with no neighbours.
- R3: Pairs presented on consecutive cycles are all accepted. Their products come out on consecutive cycles, in input order, without stalls.
- R4: `out_valid` is high in exactly those cycles whose pair, 12 cycles earlier, was sampled with `in_valid` high. Operand values on cycles with `in_valid` low do not change any valid product, even when those values are all ones.
- R5: The reset is synchronous and active high. It clears every register, so after any reset edge `out_valid` and `out_p` are 0. After reset is released, `out_valid` stays low until the pipeline has refilled, which takes at least 12 cycles.
- R6: The corner operands give the correct product with no overflow: 15*15 = 225, 0*15 = 0 and 15*0 = 0. No valid product ever exceeds (2^W-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the pair on `in_a`/`in_b` as an operation |
| in_a | input | W | Unsigned multiplicand |
| in_b | input | W | Unsigned multiplier |
| out_valid | output | 1 | Marks `out_p` as a product |
| out_p | output | 2*W | Aligned unsigned product |

## Verification
All-ones operands drive the longest carry chains, and zero operands on either side check that a one-sided zero clears every partial product. A run of back-to-back pairs exposes any cross-talk between neighbouring operations in the lattice. An isolated pair surrounded by all-ones garbage on invalid cycles shows an off-by-one latency or leakage from invalid slots. A long random stream with about three valid pairs in four covers the general product table. A reset taken mid-stream, with traffic still entering, checks that no stale operation survives.

// File: rtl/systolic_mul.sv
`timescale 1ns/1ps
module systolic_mul #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_p
);
  localparam int LAT = 3 * W;
  localparam int PW  = 2 * W;
  localparam int FW  = $clog2(LAT + 2);

  // cell (i,j) captures at edge 1+2i+j after the operands are sampled
  logic s_q  [W][W+1];
  logic c_q  [W][W];
  logic b_q  [W][W-1];
  logic a_q1 [W-1][W];
  logic a_q2 [W-1][W];
  logic a_sk [W];
  logic b_sk [W];

  for (genvar j = 0; j < W; j++) begin : g_askew
    localparam int D = j + 1;
    logic [D-1:0] sr;
    always_ff @(posedge clk)
      if (rst) sr <= '0;
      else     sr <= D'({sr, in_a[j]});
    assign a_sk[j] = sr[D-1];
  end

  for (genvar i = 0; i < W; i++) begin : g_bskew
    localparam int D = 2 * i + 1;
    logic [D-1:0] sr;
    always_ff @(posedge clk)
      if (rst) sr <= '0;
      else     sr <= D'({sr, in_b[i]});
    assign b_sk[i] = sr[D-1];
  end

  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar j = 0; j < W; j++) begin : g_cell
      logic a_in, b_in, s_in, c_in, pp;

      if (i == 0) begin : g_atop
        assign a_in = a_sk[j];
        assign s_in = 1'b0;
      end else begin : g_aup
        assign a_in = a_q2[i-1][j];
        assign s_in = s_q[i-1][j+1];
      end

      if (j == 0) begin : g_bleft
        assign b_in = b_sk[i];
        assign c_in = 1'b0;
      end else begin : g_bnbr
        assign b_in = b_q[i][j-1];
        assign c_in = c_q[i][j-1];
      end

      assign pp = a_in & b_in;

      always_ff @(posedge clk)
        if (rst) begin
          s_q[i][j] <= 1'b0;
          c_q[i][j] <= 1'b0;
        end else begin
          s_q[i][j] <= pp ^ s_in ^ c_in;
          c_q[i][j] <= (pp & s_in) | (pp & c_in) | (s_in & c_in);
        end

      if (i < W - 1) begin : g_apass
        always_ff @(posedge clk)
          if (rst) begin
            a_q1[i][j] <= 1'b0;
            a_q2[i][j] <= 1'b0;
          end else begin
            a_q1[i][j] <= a_in;
            a_q2[i][j] <= a_q1[i][j];
          end
      end

      if (j < W - 1) begin : g_bpass
        always_ff @(posedge clk)
          if (rst) b_q[i][j] <= 1'b0;
          else     b_q[i][j] <= b_in;
      end
    end

    always_ff @(posedge clk)
      if (rst) s_q[i][W] <= 1'b0;
      else     s_q[i][W] <= c_q[i][W-1];
  end

  for (genvar k = 0; k < PW; k++) begin : g_deskew
    localparam int E = (k < W - 1) ? (1 + 2 * k) : (k + W);
    localparam int D = LAT - E;
    logic src;
    logic [D-1:0] sr;
    if (k < W - 1) begin : g_early
      assign src = s_q[k][0];
    end else begin : g_last
      assign src = s_q[W-1][k-W+1];
    end
    always_ff @(posedge clk)
      if (rst) sr <= '0;
      else     sr <= D'({sr, src});
    assign out_p[k] = sr[D-1];
  end

  logic [LAT:0] vsr;
  always_ff @(posedge clk)
    if (rst) vsr <= '0;
    else     vsr <= {vsr[LAT-1:0], in_valid};
  assign out_valid = vsr[LAT];

  logic [FW-1:0] fill;
  always_ff @(posedge clk)
    if (rst)                       fill <= '0;
    else if (fill != FW'(LAT + 1)) fill <= fill + 1'b1;

  a_r5_no_early_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> fill == FW'(LAT + 1));

  a_r5_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_p == '0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_p <= PW'((2**W - 1) * (2**W - 1)));

  a_r6_row0_top_clear: assert property (@(posedge clk) disable iff (rst)
    !s_q[0][W]);

  a_r4_valid_not_reset: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> !$past(rst));
endmodule

// File: tb/systolic_mul_test.sv
`timescale 1ns/1ps
module systolic_mul_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_a = '0;
  logic [3:0] in_b = '0;
  logic       out_valid;
  logic [7:0] out_p;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit         rv [0:1023];
  logic [7:0] rp [0:1023];
  string      rt [0:1023];

  systolic_mul #(.W(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_p(out_p)
  );

  always #4 clk = ~clk;

  function automatic int ref_mul(input int a, input int b);
    return a * b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int c, input bit v, input int a, input int b, input string t);
    in_valid = v;
    in_a     = 4'(a);
    in_b     = 4'(b);
    rv[c] = v;
    rp[c] = 8'(ref_mul(a, b));
    rt[c] = t;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_a = 4'hF; in_b = 4'hF;
    @(negedge clk);
    chk("R5 valid after reset edge", int'(out_valid), 0);
    chk("R5 product after reset edge", int'(out_p), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run_phase(input int n, input int phase);
    for (int c = 0; c < n; c++) begin
      if (c < 13) chk("R5 no valid during refill", int'(out_valid), 0);
      else begin
        chk({rt[c-13], " valid"}, int'(out_valid), int'(rv[c-13]));
        if (rv[c-13]) chk({rt[c-13], " product"}, int'(out_p), int'(rp[c-13]));
      end
      if (phase == 0 && c < 13) begin
        case (c)
          0:  put(c, 1, 15, 15, "R6");
          1:  put(c, 1, 0, 15, "R6");
          2:  put(c, 1, 15, 0, "R6");
          3:  put(c, 1, 1, 1, "R1");
          4:  put(c, 1, 9, 6, "R3");
          5:  put(c, 1, 6, 9, "R3");
          6:  put(c, 1, 10, 11, "R3");
          7:  put(c, 0, 15, 15, "R4");
          8:  put(c, 0, 15, 15, "R4");
          9:  put(c, 0, 15, 15, "R2");
          10: put(c, 1, 7, 13, "R2");
          11: put(c, 0, 15, 15, "R2");
          default: put(c, 1, 12, 5, "R4");
        endcase
      end else if (phase == 1 && c < 20) begin
        put(c, 1, int'($urandom % 16), int'($urandom % 16), "R3");
      end else begin
        put(c, ($urandom % 4) != 0, int'($urandom % 16), int'($urandom % 16), "R1");
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    run_phase(300, 0);
    do_reset();
    run_phase(200, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule